// File: doc/BRIEF.md
# Secure Monitor-Register Access Checker

This block decides, for a single access to a privileged per-monitor control register, whether the access goes ahead, is refused as undefined, or is redirected as a trap to privilege level 2 or level 3. A request carries the requesting privilege level (0 to 3), the security state, the direction (read or write) and the index of the monitor being addressed. The block weighs it against the enable bits, the 2-bit per-monitor permission fields held at level 2 and at level 3, and the feature-present straps. It then produces exactly one verdict, with the exception class code that goes with a trap.

The checks run in a strict order. The security state and the privilege level are tested first. Next comes an optional early refusal driven by the level-3 controls. For level-1 requests with level 2 enabled, three level-2 checks follow. The level-3 controls are tested last, and they either refuse the access or trap to level 3. The decision is combinational on the request and is captured in an output register, so a verdict appears one clock after its request. Register storage and exception entry belong to the surrounding logic.

Top module: `secmon_access_check`

## Requirements
- R1: A request sampled with `req_valid` high at a rising edge produces `res_valid` high with its verdict after that same edge. An edge without a request, or with `rst` high, leaves `res_valid`, all four verdict flags and `res_class` at zero.
- R2: `req_sec` is encoded 0 = secure, 1 = non-secure, 2 = realm, 3 = reserved. Non-secure and reserved requests give undefined. A realm request gives undefined when `cfg_realm_present` is 1. Otherwise it is handled like a secure request.
- R3: After R2, a request from level 0 gives undefined and a request from level 3 gives allow, whatever the configuration.
- R4: The permission field for monitor s is bits [2s+1:2s] of `cfg_l3_perm` and of `cfg_l2_perm`. A read passes unless the field is 00. A write passes only when the field is 11.
- R5: The level-3 check fails when `cfg_el3_present` is 1 and either `cfg_mon_en` is 0 or the selected level-3 field fails R4. For level 1 and level 2, if `cfg_udf_early` is 1 and this check fails, the verdict is undefined, ahead of every level-2 check.
- R6: For a level-1 request with `cfg_el2_enabled` at 1, the first level-2 check is the fine-grained trap. It traps to level 2 when `cfg_fg_present` is 1 and either (`cfg_el3_present` is 1 and `cfg_fg_gate` is 0) or the per-direction bit is 0. The per-direction bit is `cfg_fg_rd` for reads and `cfg_fg_wr` for writes.
- R7: If R6 does not trap, the request then traps to level 2 when `cfg_hyp_en` is 0, and failing that, when the selected level-2 field fails R4.
- R8: A level-1 or level-2 request that reaches the level-3 check and fails it (R5) gives undefined when `cfg_udf_late` is 1 and a trap to level 3 otherwise.
- R9: Level-2 requests, and level-1 requests with `cfg_el2_enabled` at 0, skip R6 and R7 and never trap to level 2.
- R10: A level-1 or level-2 request that fails no check gives allow. An absent level 3 makes its checks pass, and an absent fine-grained trap never fires.
- R11: While `res_valid` is high exactly one of `res_allow`, `res_undef`, `res_trap2`, `res_trap3` is high. `res_class` is 0x18 with either trap flag and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_level | input | 2 | Requesting privilege level 0..3 |
| req_sec | input | 2 | Security state (0 secure, 1 non-secure, 2 realm, 3 reserved) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | SEL_W | Monitor index |
| cfg_el3_present | input | 1 | Level 3 implemented |
| cfg_el2_enabled | input | 1 | Level 2 implemented and enabled |
| cfg_fg_present | input | 1 | Fine-grained traps implemented |
| cfg_realm_present | input | 1 | Realm state implemented |
| cfg_mon_en | input | 1 | Top-level monitor access enable held at level 3 |
| cfg_l3_perm | input | 2*NUM_MON | Level-3 permission fields, two bits per monitor |
| cfg_l2_perm | input | 2*NUM_MON | Level-2 permission fields, two bits per monitor |
| cfg_hyp_en | input | 1 | Hypervisor access enable |
| cfg_fg_gate | input | 1 | Level-3 enable for fine-grained trap controls |
| cfg_fg_rd | input | 1 | Per-register fine-grained read bit (0 traps) |
| cfg_fg_wr | input | 1 | Per-register fine-grained write bit (0 traps) |
| cfg_udf_early | input | 1 | Level-3 failures refused before level-2 checks |
| cfg_udf_late | input | 1 | Late level-3 failures refused instead of trapped |
| res_valid | output | 1 | Verdict present |
| res_allow | output | 1 | Access proceeds |
| res_undef | output | 1 | Access is undefined |
| res_trap2 | output | 1 | Access traps to level 2 |
| res_trap3 | output | 1 | Access traps to level 3 |
| res_class | output | 6 | Exception class code for traps |

## Verification
The only state is the output register. A fault there appears at the ports one clock after the request that caused it, as a missing strobe, a wrong flag, two flags together, or a stale class code. Errors in check ordering only show for particular combinations of level, direction, selected field and enables. The stimulus therefore biases the enables toward their passing values, so that the deep checks are reached often, and adds directed vectors that make exactly one check in the chain decide the result.

// File: rtl/secmon_pkg.sv
package secmon_pkg;

  typedef enum logic [1:0] {
    SEC_S   = 2'd0,
    SEC_NS  = 2'd1,
    SEC_RL  = 2'd2,
    SEC_RSV = 2'd3
  } sec_e;

  typedef enum logic [1:0] {
    V_ALLOW = 2'd0,
    V_UNDEF = 2'd1,
    V_TRAP2 = 2'd2,
    V_TRAP3 = 2'd3
  } verdict_e;

  localparam logic [5:0] TRAP_CLASS = 6'h18;

  // Reads need any nonzero grant, writes need full grant.
  function automatic logic perm_ok(input logic [1:0] fld, input logic wr);
    return wr ? (fld == 2'b11) : (fld != 2'b00);
  endfunction

endpackage

// File: rtl/secmon_field_pick.sv
module secmon_field_pick #(
  parameter int NUM_MON = 4,
  parameter int SEL_W   = (NUM_MON > 1) ? $clog2(NUM_MON) : 1
) (
  input  logic [2*NUM_MON-1:0] vec,
  input  logic [SEL_W-1:0]     sel,
  output logic [1:0]           fld
);
  localparam int SPAN = 1 << SEL_W;

  logic [1:0] slot [SPAN];

  for (genvar g = 0; g < SPAN; g++) begin : g_slot
    if (g < NUM_MON) begin : g_real
      assign slot[g] = vec[2*g +: 2];
    end else begin : g_pad
      assign slot[g] = 2'b00;
    end
  end

  assign fld = slot[sel];

endmodule

// File: rtl/secmon_decide.sv
module secmon_decide
  import secmon_pkg::*;
(
  input  logic [1:0] level,
  input  logic [1:0] sec,
  input  logic       wr,
  input  logic [1:0] l3_fld,
  input  logic [1:0] l2_fld,
  input  logic       el3_present,
  input  logic       el2_enabled,
  input  logic       fg_present,
  input  logic       realm_present,
  input  logic       mon_en,
  input  logic       hyp_en,
  input  logic       fg_gate,
  input  logic       fg_rd,
  input  logic       fg_wr,
  input  logic       udf_early,
  input  logic       udf_late,
  output verdict_e   verdict
);
  logic l3_fail, l2_fail, fg_fail, l2_active, state_bad;

  always_comb begin
    l3_fail   = el3_present && (!mon_en || !perm_ok(l3_fld, wr));
    l2_fail   = !perm_ok(l2_fld, wr);
    fg_fail   = fg_present && ((el3_present && !fg_gate) || !(wr ? fg_wr : fg_rd));
    l2_active = (level == 2'd1) && el2_enabled;
    state_bad = (sec == SEC_NS) || (sec == SEC_RSV) ||
                ((sec == SEC_RL) && realm_present);

    if (state_bad)                     verdict = V_UNDEF;
    else if (level == 2'd0)            verdict = V_UNDEF;
    else if (level == 2'd3)            verdict = V_ALLOW;
    else if (udf_early && l3_fail)     verdict = V_UNDEF;
    else if (l2_active && fg_fail)     verdict = V_TRAP2;
    else if (l2_active && !hyp_en)     verdict = V_TRAP2;
    else if (l2_active && l2_fail)     verdict = V_TRAP2;
    else if (l3_fail)                  verdict = udf_late ? V_UNDEF : V_TRAP3;
    else                               verdict = V_ALLOW;
  end

endmodule

// File: rtl/secmon_access_check.sv
module secmon_access_check
  import secmon_pkg::*;
#(
  parameter int NUM_MON = 4,
  parameter int SEL_W   = (NUM_MON > 1) ? $clog2(NUM_MON) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [1:0]           req_level,
  input  logic [1:0]           req_sec,
  input  logic                 req_write,
  input  logic [SEL_W-1:0]     req_sel,
  input  logic                 cfg_el3_present,
  input  logic                 cfg_el2_enabled,
  input  logic                 cfg_fg_present,
  input  logic                 cfg_realm_present,
  input  logic                 cfg_mon_en,
  input  logic [2*NUM_MON-1:0] cfg_l3_perm,
  input  logic [2*NUM_MON-1:0] cfg_l2_perm,
  input  logic                 cfg_hyp_en,
  input  logic                 cfg_fg_gate,
  input  logic                 cfg_fg_rd,
  input  logic                 cfg_fg_wr,
  input  logic                 cfg_udf_early,
  input  logic                 cfg_udf_late,
  output logic                 res_valid,
  output logic                 res_allow,
  output logic                 res_undef,
  output logic                 res_trap2,
  output logic                 res_trap3,
  output logic [5:0]           res_class
);
  localparam int NUM_LVL = 2;  // permission vectors: index 0 = level 3, 1 = level 2

  logic [2*NUM_MON-1:0] perm_vec [NUM_LVL];
  logic [1:0]           perm_fld [NUM_LVL];
  verdict_e             verdict;

  assign perm_vec[0] = cfg_l3_perm;
  assign perm_vec[1] = cfg_l2_perm;

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_pick
    secmon_field_pick #(.NUM_MON(NUM_MON), .SEL_W(SEL_W)) u_pick (
      .vec (perm_vec[k]),
      .sel (req_sel),
      .fld (perm_fld[k])
    );
  end

  secmon_decide u_decide (
    .level         (req_level),
    .sec           (req_sec),
    .wr            (req_write),
    .l3_fld        (perm_fld[0]),
    .l2_fld        (perm_fld[1]),
    .el3_present   (cfg_el3_present),
    .el2_enabled   (cfg_el2_enabled),
    .fg_present    (cfg_fg_present),
    .realm_present (cfg_realm_present),
    .mon_en        (cfg_mon_en),
    .hyp_en        (cfg_hyp_en),
    .fg_gate       (cfg_fg_gate),
    .fg_rd         (cfg_fg_rd),
    .fg_wr         (cfg_fg_wr),
    .udf_early     (cfg_udf_early),
    .udf_late      (cfg_udf_late),
    .verdict       (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      res_valid <= 1'b0;
      res_allow <= 1'b0;
      res_undef <= 1'b0;
      res_trap2 <= 1'b0;
      res_trap3 <= 1'b0;
      res_class <= 6'h00;
    end else begin
      res_valid <= 1'b1;
      res_allow <= (verdict == V_ALLOW);
      res_undef <= (verdict == V_UNDEF);
      res_trap2 <= (verdict == V_TRAP2);
      res_trap3 <= (verdict == V_TRAP3);
      res_class <= (verdict == V_TRAP2 || verdict == V_TRAP3) ? TRAP_CLASS : 6'h00;
    end
  end

  // R1: strobe follows request by one edge, idle outputs are clear
  assert_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  assert_nostrobe_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ({res_allow, res_undef, res_trap2, res_trap3} == 4'b0 && res_class == 6'h00));

  // R2: non-secure requests are refused
  assert_nonsec_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sec == SEC_NS) |=> res_undef);

  // R3: level 0 refused, level 3 allowed from secure state
  assert_lvl0_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sec == SEC_S && req_level == 2'd0) |=> res_undef);
  assert_lvl3_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sec == SEC_S && req_level == 2'd3) |=> res_allow);

  // R9: only level-1 requests with level 2 enabled may trap to level 2
  assert_no_trap2_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_level != 2'd1 || !cfg_el2_enabled)) |=> !res_trap2);

  // R11: one verdict, class code tied to traps
  assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $countones({res_allow, res_undef, res_trap2, res_trap3}) == 1);
  assert_class_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_class == ((res_trap2 || res_trap3) ? TRAP_CLASS : 6'h00)));

endmodule

// File: tb/tb_secmon_access_check.sv
`timescale 1ns/1ps
module tb_secmon_access_check;
  localparam int NUM_MON = 4;
  localparam int SEL_W   = 2;
  localparam int N_RAND  = 4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_level = '0, req_sec = '0;
  logic req_write = 1'b0;
  logic [SEL_W-1:0] req_sel = '0;
  logic el3p, el2e, fgp, rlmp, mon_en, hyp_en, fg_gate, fg_rd, fg_wr, udf_e, udf_l;
  logic [2*NUM_MON-1:0] l3p, l2p;
  logic res_valid, res_allow, res_undef, res_trap2, res_trap3;
  logic [5:0] res_class;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;  // 50 MHz

  secmon_access_check #(.NUM_MON(NUM_MON)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
    .req_sec(req_sec), .req_write(req_write), .req_sel(req_sel),
    .cfg_el3_present(el3p), .cfg_el2_enabled(el2e), .cfg_fg_present(fgp),
    .cfg_realm_present(rlmp), .cfg_mon_en(mon_en), .cfg_l3_perm(l3p),
    .cfg_l2_perm(l2p), .cfg_hyp_en(hyp_en), .cfg_fg_gate(fg_gate),
    .cfg_fg_rd(fg_rd), .cfg_fg_wr(fg_wr), .cfg_udf_early(udf_e),
    .cfg_udf_late(udf_l), .res_valid(res_valid), .res_allow(res_allow),
    .res_undef(res_undef), .res_trap2(res_trap2), .res_trap3(res_trap3),
    .res_class(res_class)
  );

  // expected flags {allow, undef, trap2, trap3}, with the deciding requirement
  function automatic logic [3:0] model(output string tag);
    logic [1:0] f3, f2;
    logic ok3, ok2, fail3, fgf, act2;
    f3 = l3p[2*req_sel +: 2];
    f2 = l2p[2*req_sel +: 2];
    ok3 = req_write ? (f3 == 2'b11) : (f3 != 2'b00);
    ok2 = req_write ? (f2 == 2'b11) : (f2 != 2'b00);
    fail3 = el3p && (!mon_en || !ok3);
    fgf = fgp && ((el3p && !fg_gate) || !(req_write ? fg_wr : fg_rd));
    act2 = (req_level == 2'd1) && el2e;
    if (req_sec == 2'd1 || req_sec == 2'd3 || (req_sec == 2'd2 && rlmp)) begin tag = "R2"; return 4'b0100; end
    if (req_level == 2'd0) begin tag = "R3"; return 4'b0100; end
    if (req_level == 2'd3) begin tag = "R3"; return 4'b1000; end
    if (udf_e && fail3) begin tag = "R5"; return 4'b0100; end
    if (act2 && fgf) begin tag = "R6"; return 4'b0010; end
    if (act2 && (!hyp_en || !ok2)) begin tag = "R7"; return 4'b0010; end
    if (fail3) begin tag = "R8"; return udf_l ? 4'b0100 : 4'b0001; end
    tag = (req_level == 2'd2) ? "R9" : "R10";
    return 4'b1000;
  endfunction

  task automatic compare(input logic v, input logic [3:0] fl, input string tag);
    logic [5:0] cls;
    cls = (v && (fl[1] || fl[0])) ? 6'h18 : 6'h00;
    vectors++;
    if (res_valid !== v || {res_allow, res_undef, res_trap2, res_trap3} !== fl || res_class !== cls) begin
      miscompares++;
      $display("FAIL %s (R11 class/flags): got v=%b flags=%b class=%h expected v=%b flags=%b class=%h",
               tag, res_valid, {res_allow, res_undef, res_trap2, res_trap3}, res_class, v, fl, cls);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic apply();
    logic [3:0] e;
    string tag;
    req_valid = 1'b1;
    e = model(tag);
    @(negedge clk);
    compare(1'b1, e, tag);
  endtask

  task automatic all_pass();
    el3p = 1; el2e = 1; fgp = 1; rlmp = 1; mon_en = 1; hyp_en = 1;
    fg_gate = 1; fg_rd = 1; fg_wr = 1; udf_e = 0; udf_l = 0;
    l3p = '1; l2p = '1; req_sec = 2'd0; req_level = 2'd1; req_write = 0; req_sel = '0;
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    all_pass();
    repeat (3) @(negedge clk);
    compare(1'b0, 4'b0000, "R1 reset");
    rst = 1'b0;

    // R10 baseline, R1 idle after request
    apply();
    req_valid = 1'b0;
    @(negedge clk);
    compare(1'b0, 4'b0000, "R1 idle");

    // R2 realm with and without realm support
    all_pass(); req_sec = 2'd2; apply();
    rlmp = 0; apply();
    // R4 field position and thresholds: monitor 2 field = 01
    all_pass(); req_level = 2'd2; l3p = 8'b11_01_11_11; req_sel = 2'd2; apply();  // read passes
    req_write = 1; apply();                                                        // write traps to 3 (R8)
    udf_l = 1; apply();                                                            // write refused (R8)
    req_sel = 2'd1; apply();                                                       // neighbour field 11: R4 allow
    // R5 early refusal ahead of level-2 traps
    all_pass(); hyp_en = 0; mon_en = 0; udf_e = 1; apply();
    udf_e = 0; apply();                                                            // R7 trap2 wins
    // R6 fine-grained by direction and gate
    all_pass(); fg_wr = 0; apply();                                                // read unaffected
    req_write = 1; apply();                                                        // trap2
    all_pass(); fg_gate = 0; apply();
    el3p = 0; apply();                                                             // gate ignored without level 3
    // R7 level-2 field, R9 skip at level 2
    all_pass(); l2p = '0; apply();
    req_level = 2'd2; apply();
    // R3 level 3 despite everything failing
    all_pass(); mon_en = 0; l3p = '0; req_level = 2'd3; apply();

    for (int i = 0; i < N_RAND; i++) begin
      int r;
      r = $urandom % 8;
      req_sec   = (r < 5) ? 2'd0 : 2'(r - 4);
      req_level = 2'($urandom % 4);
      req_write = 1'($urandom);
      req_sel   = SEL_W'($urandom);
      el3p = ($urandom % 4) != 0; el2e = ($urandom % 4) != 0;
      fgp = 1'($urandom); rlmp = 1'($urandom);
      mon_en = ($urandom % 5) != 0; hyp_en = ($urandom % 5) != 0;
      fg_gate = ($urandom % 5) != 0; fg_rd = ($urandom % 5) != 0; fg_wr = ($urandom % 5) != 0;
      udf_e = 1'($urandom); udf_l = 1'($urandom);
      l3p = 8'($urandom); l2p = 8'($urandom);
      apply();
    end

    req_valid = 1'b0;
    @(negedge clk);
    compare(1'b0, 4'b0000, "R1 final idle");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule